// File: doc/BRIEF.md
# Lockstep Output Comparator with Fault Injection

This block sits between a main core and its checker core that run the same program in lockstep. Each clock cycle it compares the two cores' output vectors. Any difference raises a one-cycle compare-error pulse and sets a sticky fail flag. Software clears that flag by writing 1 to it. The comparator also carries a small self-test checker: a second, independently built reduction that must always agree with the main one. Any disagreement between the two raises a separate self-test error pulse.

A 4-bit mode key, written through a simple register port, starts one of two diagnostic runs.

- **Compare-path forcing** injects a mismatch into the main comparison. This proves that the compare-error path and the status flag work.
- **Self-test forcing** drives a mismatch into the self-test checker only. This proves that the self-test error path works, and it leaves the status register alone.

Both runs last one cycle at the default parameters. Afterwards the block returns to plain lockstep comparison with no further write. Software can poll the error outputs through the downstream error aggregator to confirm that each diagnostic ran.

Top module: `lockstep_cmp_diag`

## Requirements
- R1: After reset, `cmp_err` and `st_err` are low, the key register reads 0x0 and the status register reads 0x00.
- R2: In normal mode, a difference in any bit between `main_vec` and `chk_vec` in a cycle drives `cmp_err` high in the following cycle and sets status bit 0 (compare fail).
- R3: Status bit 0 is sticky. `cmp_err` is high only in cycles that follow a mismatching or forced cycle, so a single-cycle mismatch gives a single-cycle pulse.
- R4: The register map is:
  - Offset 0: key register, bits [3:0].
  - Offset 1: status register. Bit 0 is compare fail; bits [7:1] read 0.
  - Writing 1 to a status bit clears it. Writing 0 has no effect. A set in the same cycle as a clear wins.
- R5: Writing key 0x9 in normal mode starts compare-path forcing, and the key reads 0x9 during the forcing cycle. The forced mismatch is applied in the cycle after the write. `cmp_err` then pulses once in the cycle after that, and status bit 0 is set.
- R6: When a forcing run ends, the key register reads 0x0 and the block compares normally again, with no software write.
- R7: Writing key 0xF in normal mode applies a mismatch to the self-test checker for exactly one cycle. `st_err` pulses once, two cycles after the write cycle, and `cmp_err` stays low.
- R8: Self-test forcing leaves every status bit unchanged. The status reads 0x00 throughout if no genuine mismatch occurs.
- R9: A key write that arrives while a forcing run is in progress is ignored. It neither changes the key nor starts a new run.
- R10: A key value other than 0x9 or 0xF is stored and read back, and the block stays in normal compare with no injected error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset: 0 is the key, 1 is the status |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` (combinational) |
| main_vec | input | DATA_W | Output vector of the main core |
| chk_vec | input | DATA_W | Output vector of the checker core |
| cmp_err | output | 1 | Lockstep compare-error pulse |
| st_err | output | 1 | Self-test error pulse |

## Verification
The bench targets the following corner cases:

- **Forced self-test.** It checks that a forced self-test leaves the status at zero. A design that routed the self-test fault through the main compare path would set the flag and pulse `cmp_err` instead.
- **Overlapping key write.** It writes 0xF during a 0x9 run and then reads the key as 0x0 with no self-test pulse. A design that accepted the overlapping write would show 0xF or fire `st_err`.
- **Status write rules.** It checks that a zero write leaves the flag set, and that a mismatch in the same cycle as a clear keeps the flag. A design that gave the clear priority would drop a real fault.
- **Mismatch position.** It applies mismatches in both the lowest and the highest bit. This catches a comparator that leaves out one lane.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL    = 2'd0,
      MODE_ERR_FORCE = 2'd1,
      MODE_ST_FORCE  = 2'd2
   } lsc_mode_e;

   function automatic int unsigned lanes_for(input int unsigned width, input int unsigned lane);
      return (width + lane - 1) / lane;
   endfunction

endpackage

// File: rtl/lsc_key_ctrl.sv
module lsc_key_ctrl
   import lsc_pkg::*;
#(
   parameter int unsigned KEY_W         = 4,
   parameter logic [3:0]  KEY_ERR_FORCE = 4'h9,
   parameter logic [3:0]  KEY_ST_FORCE  = 4'hF,
   parameter int unsigned FORCE_LEN     = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_wdata,
   output logic [KEY_W-1:0] key_q,
   output lsc_mode_e        mode_q
);
   localparam int unsigned CNT_W = (FORCE_LEN > 1) ? $clog2(FORCE_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FORCE_LEN - 1);

   generate
      if (KEY_W != 4) begin : g_bad_key_w
         $error("lsc_key_ctrl: KEY_W must be 4");
      end
      if (FORCE_LEN < 1) begin : g_bad_len
         $error("lsc_key_ctrl: FORCE_LEN must be at least 1");
      end
      if (KEY_ERR_FORCE == KEY_ST_FORCE) begin : g_bad_keys
         $error("lsc_key_ctrl: forcing keys must differ");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             accept;
   logic             last;

   assign accept = key_wr && (mode_q == MODE_NORMAL);
   assign last   = (mode_q != MODE_NORMAL) && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         mode_q <= MODE_NORMAL;
         cnt_q  <= '0;
      end else if (accept) begin
         key_q <= key_wdata;
         cnt_q <= '0;
         if (key_wdata == KEY_ERR_FORCE)     mode_q <= MODE_ERR_FORCE;
         else if (key_wdata == KEY_ST_FORCE) mode_q <= MODE_ST_FORCE;
         else                                mode_q <= MODE_NORMAL;
      end else if (last) begin
         key_q  <= '0;
         mode_q <= MODE_NORMAL;
         cnt_q  <= '0;
      end else if (mode_q != MODE_NORMAL) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (mode_q == MODE_NORMAL && key_q == '0)); // R6

   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_NORMAL && !last) |=> (key_q == $past(key_q) && mode_q == $past(mode_q))); // R9

   AST_OTHER_KEY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && key_wdata != KEY_ERR_FORCE && key_wdata != KEY_ST_FORCE) |=> (mode_q == MODE_NORMAL)); // R10

endmodule

// File: rtl/lsc_compare.sv
module lsc_compare
   import lsc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LANE_W     = 8,
   parameter bit          REG_INPUTS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] main_vec,
   input  logic [DATA_W-1:0] chk_vec,
   input  lsc_mode_e         mode,
   output logic              cmp_err_d,
   output logic              cmp_err_q,
   output logic              st_err_q,
   output logic              real_mismatch
);
   localparam int unsigned NUM_LANES = lanes_for(DATA_W, LANE_W);
   localparam int unsigned PAD_W     = NUM_LANES * LANE_W;

   generate
      if (DATA_W < 1 || LANE_W < 1) begin : g_bad_w
         $error("lsc_compare: widths must be positive");
      end
      if (LANE_W > DATA_W) begin : g_bad_lane
         $error("lsc_compare: LANE_W must not exceed DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] a_v, b_v;

   generate
      if (REG_INPUTS) begin : g_in_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_v <= '0;
               b_v <= '0;
            end else begin
               a_v <= main_vec;
               b_v <= chk_vec;
            end
         end
      end else begin : g_in_wire
         assign a_v = main_vec;
         assign b_v = chk_vec;
      end
   endgenerate

   logic [PAD_W-1:0]     a_pad, b_pad;
   logic [NUM_LANES-1:0] lane_diff;
   logic [NUM_LANES-1:0] shadow_diff;
   logic [NUM_LANES-1:0] st_flip;

   assign a_pad = PAD_W'(a_v);
   assign b_pad = PAD_W'(b_v);

   genvar gl;
   generate
      for (gl = 0; gl < NUM_LANES; gl++) begin : g_lane
         logic [LANE_W-1:0] la, lb;
         assign la = a_pad[gl*LANE_W +: LANE_W];
         assign lb = b_pad[gl*LANE_W +: LANE_W];
         assign lane_diff[gl]   = |(la ^ lb);
         assign shadow_diff[gl] = (la != lb);
      end
   endgenerate

   assign st_flip = (mode == MODE_ST_FORCE) ? NUM_LANES'(1) : '0;

   logic st_disagree;
   assign real_mismatch = |lane_diff;
   assign st_disagree   = |(lane_diff ^ (shadow_diff ^ st_flip));
   assign cmp_err_d     = real_mismatch || (mode == MODE_ERR_FORCE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_err_q <= 1'b0;
         st_err_q  <= 1'b0;
      end else begin
         cmp_err_q <= cmp_err_d;
         st_err_q  <= st_disagree;
      end
   end

   AST_MISMATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (a_v != b_v) |=> cmp_err_q); // R2

   AST_QUIET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (a_v == b_v && mode == MODE_NORMAL) |=> !cmp_err_q); // R3

   AST_ERR_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ERR_FORCE) |=> cmp_err_q); // R5

   AST_ST_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ST_FORCE) |=> st_err_q); // R7

endmodule

// File: rtl/lsc_status.sv
module lsc_status #(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_fail,
   input  logic             clr_wr,
   input  logic [REG_W-1:0] clr_mask,
   output logic [REG_W-1:0] status_q
);
   generate
      if (REG_W < 1) begin : g_bad_w
         $error("lsc_status: REG_W must be positive");
      end
   endgenerate

   logic fail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      fail_q <= 1'b0;
      else if (set_fail)               fail_q <= 1'b1;
      else if (clr_wr && clr_mask[0])  fail_q <= 1'b0;
   end

   assign status_q = REG_W'(fail_q);

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_q && !(clr_wr && clr_mask[0])) |=> fail_q); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_fail |=> fail_q); // R4

endmodule

// File: rtl/lockstep_cmp_diag.sv
module lockstep_cmp_diag
   import lsc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LANE_W     = 8,
   parameter bit          REG_INPUTS = 1'b0,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned FORCE_LEN  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [DATA_W-1:0] main_vec,
   input  logic [DATA_W-1:0] chk_vec,
   output logic              cmp_err,
   output logic              st_err
);
   localparam int unsigned KEY_W = 4;
   localparam logic [ADDR_W-1:0] OFS_KEY  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(1);

   generate
      if (REG_W < KEY_W) begin : g_bad_reg_w
         $error("lockstep_cmp_diag: REG_W must hold the key");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("lockstep_cmp_diag: ADDR_W must be positive");
      end
   endgenerate

   logic             wr_key, wr_stat;
   logic [KEY_W-1:0] key_q;
   lsc_mode_e        mode_q;
   logic [REG_W-1:0] status_q;
   logic             cmp_err_d;
   logic             real_mismatch;

   assign wr_key  = reg_wr && (reg_addr == OFS_KEY);
   assign wr_stat = reg_wr && (reg_addr == OFS_STAT);

   lsc_key_ctrl #(
      .KEY_W    (KEY_W),
      .FORCE_LEN(FORCE_LEN)
   ) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (wr_key),
      .key_wdata(reg_wdata[KEY_W-1:0]),
      .key_q    (key_q),
      .mode_q   (mode_q)
   );

   lsc_compare #(
      .DATA_W    (DATA_W),
      .LANE_W    (LANE_W),
      .REG_INPUTS(REG_INPUTS)
   ) u_cmp (
      .clk          (clk),
      .rst_n        (rst_n),
      .main_vec     (main_vec),
      .chk_vec      (chk_vec),
      .mode         (mode_q),
      .cmp_err_d    (cmp_err_d),
      .cmp_err_q    (cmp_err),
      .st_err_q     (st_err),
      .real_mismatch(real_mismatch)
   );

   lsc_status #(
      .REG_W(REG_W)
   ) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_fail(cmp_err_d),
      .clr_wr  (wr_stat),
      .clr_mask(reg_wdata),
      .status_q(status_q)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_KEY)       reg_rdata = REG_W'(key_q);
      else if (reg_addr == OFS_STAT) reg_rdata = status_q;
   end

   AST_ST_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_ST_FORCE && !real_mismatch && !wr_stat) |=> $stable(status_q)); // R8

   AST_ST_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_ST_FORCE && !real_mismatch) |=> !cmp_err); // R7

endmodule

// File: tb/lockstep_cmp_diag_test.sv
module lockstep_cmp_diag_test;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic [DW-1:0] main_vec = '0;
   logic [DW-1:0] chk_vec = '0;
   logic          cmp_err, st_err;

   always #4 clk = ~clk;

   lockstep_cmp_diag uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_vec(main_vec),
      .chk_vec(chk_vec), .cmp_err(cmp_err), .st_err(st_err)
   );

   typedef struct {
      logic       cmp;
      logic       st;
      logic [7:0] rd;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   localparam logic [DW-1:0] A = 32'h5A3C_96E1;

   // driver: applies one cycle of stimulus and queues the outputs expected at the next falling edge
   task automatic step(input logic wr, input logic [1:0] addr, input logic [7:0] wd,
                       input logic [DW-1:0] m, input logic [DW-1:0] c,
                       input logic ecmp, input logic est, input logic [7:0] erd, input string tag);
      exp_t e;
      @(posedge clk);
      #2;
      reg_wr = wr; reg_addr = addr; reg_wdata = wd; main_vec = m; chk_vec = c;
      e.cmp = ecmp; e.st = est; e.rd = erd; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_checks++;
         if (cmp_err !== e.cmp || st_err !== e.st || reg_rdata !== e.rd) begin
            n_fail++;
            $display("FAIL %s: got cmp=%0b st=%0b rd=%02h, expected cmp=%0b st=%0b rd=%02h",
                     e.tag, cmp_err, st_err, reg_rdata, e.cmp, e.st, e.rd);
         end
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #2 rst_n = 1'b1;
            step(0, 1, 0, A, A, 0, 0, 8'h00, "R1 reset status");
            step(0, 0, 0, A, A, 0, 0, 8'h00, "R1 reset key");
            // genuine mismatch, lowest bit
            step(0, 1, 0, A, A ^ 32'h1, 0, 0, 8'h00, "R2 before mismatch");
            step(0, 1, 0, A, A, 1, 0, 8'h01, "R2 pulse and flag");
            step(0, 1, 0, A, A, 0, 0, 8'h01, "R3 single pulse, flag sticky");
            step(1, 1, 8'h00, A, A, 0, 0, 8'h01, "R4 zero write issued");
            step(0, 1, 0, A, A, 0, 0, 8'h01, "R4 zero write no effect");
            step(1, 1, 8'h01, A, A, 0, 0, 8'h01, "R4 clear issued");
            step(0, 1, 0, A, A, 0, 0, 8'h00, "R4 cleared");
            // compare-path forcing, with an overlapping 0xF write
            step(1, 0, 8'h09, A, A, 0, 0, 8'h00, "R5 key write");
            step(1, 0, 8'h0F, A, A, 0, 0, 8'h09, "R5 key during run");
            step(0, 1, 0, A, A, 1, 0, 8'h01, "R5 forced pulse and flag");
            step(0, 0, 0, A, A, 0, 0, 8'h00, "R6 R9 key back to zero, no self-test");
            step(0, 1, 0, A, A, 0, 0, 8'h01, "R5 single forced pulse");
            step(1, 1, 8'h01, A, A, 0, 0, 8'h01, "R4 clear after forcing");
            step(0, 1, 0, A, A ^ 32'h8000_0000, 0, 0, 8'h00, "R6 normal compare resumed");
            step(0, 1, 0, A, A, 1, 0, 8'h01, "R2 top bit mismatch");
            step(1, 1, 8'h01, A, A, 0, 0, 8'h01, "R4 clear");
            // self-test forcing
            step(1, 0, 8'h0F, A, A, 0, 0, 8'h00, "R7 key write");
            step(0, 1, 0, A, A, 0, 0, 8'h00, "R8 status during run");
            step(0, 1, 0, A, A, 0, 1, 8'h00, "R7 R8 self-test pulse, status zero");
            step(0, 0, 0, A, A, 0, 0, 8'h00, "R7 R6 single pulse, key zero");
            // other key value
            step(1, 0, 8'h05, A, A, 0, 0, 8'h00, "R10 key write");
            step(0, 0, 0, A, A, 0, 0, 8'h05, "R10 key read back");
            step(0, 1, 0, A, A, 0, 0, 8'h00, "R10 no forced error");
            step(0, 1, 0, A, A, 0, 0, 8'h00, "R10 still quiet");
            // set wins over a simultaneous clear
            step(1, 1, 8'h01, A, A ^ 32'h0000_0200, 0, 0, 8'h00, "R4 set and clear together");
            step(0, 1, 0, A, A, 1, 0, 8'h01, "R4 set wins");
            step(0, 1, 0, A, A, 0, 0, 8'h01, "R3 flag holds");
            @(posedge clk);
            @(posedge clk);
            done = 1'b1;
         end
         begin
            repeat (2000) @(posedge clk);
            if (!done) begin
               n_checks++;
               n_fail++;
               $display("FAIL watchdog: got timeout, expected completion");
            end
         end
      join_any
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule